// File: doc/BRIEF.md
# Burst Address Sequencer with Wait Control

This block produces the word address that a synchronous burst SRAM presents to its array during a four-beat burst. A new external address is captured when either of two active-low address strobes is asserted while the bank is enabled. After that, each cycle with both strobes idle either steps the two low-order address bits to the next beat or, when the advance input is inactive, stalls the burst in place. The address bits above the burst field never change inside a burst. They always hold the value that was captured.

A static ordering input selects how the low bits move through a burst. With the input low the ordering is interleaved: the start offset is XORed with a beat count. With the input high the ordering is linear: the start offset plus the beat count, wrapping modulo four. The sequencer does not stop after the fourth beat. Further advances keep walking the same four-word block. A single-cycle flag marks the cycle in which a freshly captured address is on the output.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset drives the address output to all zeros and the start flag low on the next cycle, whatever the other inputs are. The beat count is cleared, so a later advance from reset produces offset 01 in either ordering.
- R2: If bank_en is high and strobe_p_n, strobe_c_n or both are low at a rising edge, the full input address appears on addr_out from that edge on, and burst_start is high for exactly that one cycle.
- R3: A strobe that is low while bank_en is low loads nothing and advances nothing. The address output keeps its value and burst_start is low, whatever adv_n is.
- R4: If both strobes are high, bank_en is high and adv_n is low, the burst moves to its next beat. Only the two lowest address bits may change, and burst_start is low.
- R5: If both strobes are high and adv_n is high, the cycle is a wait cycle. addr_out keeps its value and burst_start is low.
- R6: With ordering_lin low (interleaved), beat k of a burst that started at offset s has offset s XOR k. For example, start 01 gives 01,00,11,10 and start 11 gives 11,10,01,00.
- R7: With ordering_lin high (linear), beat k has offset (s + k) mod 4. For example, start 01 gives 01,10,11,00 and start 11 gives 11,00,01,10.
- R8: A fifth advance returns to the start offset and the walk repeats. There is never a carry out of the two low bits into the upper bits.
- R9: A load has priority over an advance or a wait in the same cycle. The new address is taken and the beat count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External address to capture |
| strobe_p_n | input | 1 | First address strobe, active low |
| strobe_c_n | input | 1 | Second address strobe, active low |
| bank_en | input | 1 | Bank enable, active high; qualifies both strobes |
| adv_n | input | 1 | Advance, active low; high makes an idle cycle a wait |
| ordering_lin | input | 1 | Static ordering select: 0 interleaved, 1 linear |
| addr_out | output | ADDR_W | Current burst address |
| burst_start | output | 1 | High in the cycle a newly captured address is presented |

## Verification
The interesting collision is a strobe arriving in the same cycle as an advance request. The other one is a strobe arriving during a wait, where the address must be captured and the beat count must start again. The bench drives a strobe together with adv_n low in the middle of a linear burst, then advances once. The new address must appear unchanged with burst_start high, and the following beat must be start plus one rather than a continuation of the old beat count. A reset arriving with a strobe active is also checked, and the result must be all zeros.

// File: rtl/bas_pkg.sv
package bas_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2
    } bas_cmd_e;

endpackage

// File: rtl/bas_cmd_decode.sv
module bas_cmd_decode
    import bas_pkg::*;
(
    input  logic     strobe_p_n,
    input  logic     strobe_c_n,
    input  logic     bank_en,
    input  logic     adv_n,
    output bas_cmd_e cmd
);

    logic any_strobe;

    always_comb begin
        any_strobe = !strobe_p_n || !strobe_c_n;
        if (any_strobe && bank_en) begin
            cmd = CMD_LOAD;               // capture wins over step and wait
        end else if (!any_strobe && bank_en && !adv_n) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;               // wait cycle or unqualified strobe
        end
    end

endmodule

// File: rtl/bas_order.sv
module bas_order #(
    parameter int OFS_W = 2
) (
    input  logic [OFS_W-1:0] start_ofs,
    input  logic [OFS_W-1:0] beat,
    input  logic             ordering_lin,
    output logic [OFS_W-1:0] ofs
);

    logic [OFS_W-1:0] ofs_xor;
    logic [OFS_W-1:0] ofs_add;

    always_comb begin
        ofs_xor = start_ofs ^ beat;
        ofs_add = start_ofs + beat;       // truncation gives the modulo wrap
        ofs     = ordering_lin ? ofs_add : ofs_xor;
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_p_n,
    input  logic              strobe_c_n,
    input  logic              bank_en,
    input  logic              adv_n,
    input  logic              ordering_lin,
    output logic [ADDR_W-1:0] addr_out,
    output logic              burst_start
);

    localparam int UP_W = ADDR_W - OFS_W;

    typedef struct packed {
        logic [UP_W-1:0]  upper;
        logic [OFS_W-1:0] start;
        logic [OFS_W-1:0] beat;
        logic             fresh;
    } seq_state_t;

    seq_state_t       st_d, st_q;
    bas_cmd_e         cmd;
    logic [OFS_W-1:0] cur_ofs;

    bas_cmd_decode u_dec (
        .strobe_p_n (strobe_p_n),
        .strobe_c_n (strobe_c_n),
        .bank_en    (bank_en),
        .adv_n      (adv_n),
        .cmd        (cmd)
    );

    bas_order #(.OFS_W(OFS_W)) u_ord (
        .start_ofs    (st_q.start),
        .beat         (st_q.beat),
        .ordering_lin (ordering_lin),
        .ofs          (cur_ofs)
    );

    always_comb begin
        st_d       = st_q;
        st_d.fresh = 1'b0;
        if (rst) begin
            st_d = '0;
        end else begin
            case (cmd)
                CMD_LOAD: begin
                    st_d.upper = addr_in[ADDR_W-1:OFS_W];
                    st_d.start = addr_in[OFS_W-1:0];
                    st_d.beat  = '0;
                    st_d.fresh = 1'b1;
                end
                CMD_STEP: st_d.beat = st_q.beat + 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign addr_out    = {st_q.upper, cur_ofs};
    assign burst_start = st_q.fresh;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (addr_out == '0 && !burst_start));

    a_r2_load_captures: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD) |=> (addr_out == $past(addr_in) && burst_start));

    a_r5_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_HOLD && $stable(ordering_lin))
            |=> ($stable(addr_out) && !burst_start));

    a_r4_step_low_only: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STEP)
            |=> ($stable(addr_out[ADDR_W-1:OFS_W]) && !burst_start));

    a_r8_no_carry: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_LOAD) |=> $stable(addr_out[ADDR_W-1:OFS_W]));

    a_r4_step_moves: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STEP && $stable(ordering_lin))
            |=> (addr_out[OFS_W-1:0] != $past(addr_out[OFS_W-1:0])));

endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;

    localparam int AW = 16;

    typedef struct packed {
        logic          rst;
        logic          sp_n;
        logic          sc_n;
        logic          en;
        logic          adv_n;
        logic          lin;
        logic [AW-1:0] a_in;
        logic [AW-1:0] exp_a;
        logic          exp_bs;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,16'h0000,16'h0000,1'b0,8'd1}, // R1
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,16'h1235,16'h1235,1'b1,8'd2}, // R2 first strobe
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,16'hFFFF,16'h1234,1'b0,8'd6}, // R6 01->00
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,16'hFFFF,16'h1237,1'b0,8'd6}, // R6 ->11
        '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,16'hFFFF,16'h1237,1'b0,8'd5}, // R5 wait
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,16'hFFFF,16'h1236,1'b0,8'd6}, // R6 ->10
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,16'hFFFF,16'h1235,1'b0,8'd8}, // R8 wrap
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,16'hABCB,16'hABCB,1'b1,8'd2}, // R2 second strobe
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,16'h5550,16'hABCB,1'b0,8'd3}, // R3 no bank
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,16'h5550,16'hABCB,1'b0,8'd3}, // R3 with adv
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,16'h7FFD,16'h7FFD,1'b1,8'd2}, // R2 linear load
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,16'h0000,16'h7FFE,1'b0,8'd7}, // R7
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,16'h0000,16'h7FFF,1'b0,8'd7}, // R7
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,16'h0000,16'h7FFC,1'b0,8'd8}, // R8 no carry
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,16'h0000,16'h7FFD,1'b0,8'd8}, // R8 wrap
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,16'h0102,16'h0102,1'b1,8'd9}, // R9 load+adv
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,16'h0000,16'h0103,1'b0,8'd9}, // R9 beat restart
        '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,16'h0000,16'h0103,1'b0,8'd5}, // R5
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,16'h0F0F,16'h0F0F,1'b1,8'd2}, // R2 both strobes
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,16'h4444,16'h0000,1'b0,8'd1}  // R1 over strobe
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          strobe_p_n = 1'b1;
    logic          strobe_c_n = 1'b1;
    logic          bank_en = 1'b0;
    logic          adv_n = 1'b1;
    logic          ordering_lin = 1'b0;
    logic [AW-1:0] addr_out;
    logic          burst_start;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .OFS_W(2)) uut (
        .clk          (clk),
        .rst          (rst),
        .addr_in      (addr_in),
        .strobe_p_n   (strobe_p_n),
        .strobe_c_n   (strobe_c_n),
        .bank_en      (bank_en),
        .adv_n        (adv_n),
        .ordering_lin (ordering_lin),
        .addr_out     (addr_out),
        .burst_start  (burst_start)
    );

    task automatic drive(input logic r, input logic sp, input logic sc, input logic en,
                         input logic adv, input logic lin, input logic [AW-1:0] a);
        rst = r; strobe_p_n = sp; strobe_c_n = sc; bank_en = en;
        adv_n = adv; ordering_lin = lin; addr_in = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input int req, input logic [AW-1:0] ea, input logic eb);
        checks++;
        if (addr_out !== ea || burst_start !== eb) begin
            fails++;
            $display("FAIL R%0d: addr_out=%h burst_start=%b expected addr_out=%h burst_start=%b",
                     req, addr_out, burst_start, ea, eb);
        end
    endtask

    initial begin
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].rst, VECS[i].sp_n, VECS[i].sc_n, VECS[i].en,
                  VECS[i].adv_n, VECS[i].lin, VECS[i].a_in);
            check(int'(VECS[i].req), VECS[i].exp_a, VECS[i].exp_bs);
        end

        // R1: beat count cleared by reset; the first advance gives offset 01
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000);
        check(1, 16'h0001, 1'b0);

        // R6 / R7: every start offset in both orderings, four beats plus one wrap
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                logic [AW-1:0] base;
                base = 16'hC3A0 | AW'(s);
                drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, m[0], base);
                check(2, base, 1'b1);
                for (int k = 1; k <= 4; k++) begin
                    logic [1:0] eo;
                    eo = (m == 0) ? (2'(s) ^ 2'(k)) : 2'(s + k);
                    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, m[0], 16'h0000);
                    check((m == 0) ? 6 : 7, {base[AW-1:2], eo}, 1'b0);
                end
            end
        end

        // R9: load during a wait restarts the beat count
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0000);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h2222);
        check(9, 16'h2222, 1'b1);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0000);
        check(9, 16'h2223, 1'b0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule